// File: doc/BRIEF.md
# Ramp Converter Conversion Sequencer

This block is the digital half of a per-channel single-slope converter for a sampled waveform store. The channel holds 64 sample cells and one extra time-over-threshold cell. A time base counter runs freely outside the block and several channels share it. It is never cleared for a conversion. When an event arrives while the channel is idle, the sequencer records the counter value as the ramp start point and raises `busy_o`, which also keeps the analog ramp running. From then on, each cell's comparator flag freezes the counter value of that cycle into the cell's code register.

The conversion ends on the first cycle in which every cell holds a code, so small signals finish early. If that does not happen, it ends when the full-scale count for the chosen resolution is reached. Cells that never fired then receive the all-ones code. The resolution can be set from 7 to 11 bits, which trades precision for dead time. In subtracting mode, each code is the counter value minus the ramp start point, taken modulo two to the resolution, so a counter wrap inside a conversion does no harm.

Top module: `rampadc_ctrl`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, `ramp_ofs_o` is 0 and every cell code is 0.
- R2: A high `trig_i` sampled on a rising edge while `busy_o` is 0 sets `busy_o` to 1 from the next cycle. The same edge loads the `tbase_i` value present at that edge into `ramp_ofs_o`.
- R3: In raw mode (`auto_sub_i` = 0 at the trigger), cell i (code at `codes_o[i*11 +: 11]`) stores `tbase_i` AND mask. Here `tbase_i` is the value at the first rising edge during busy at which `cmp_hit_i[i]` is 1, and mask keeps the low `bits` bits.
- R4: In subtracting mode (`auto_sub_i` = 1 at the trigger), that cell code is (`tbase_i` − `ramp_ofs_o`) mod 2^bits, which covers counter wrap-around.
- R5: Once a cell holds a code, later values of its comparator flag leave the code unchanged.
- R6: On the rising edge where the last cell without a code gets one, the conversion ends. `done_o` is 1 and `busy_o` is 0 in the following cycle.
- R7: Busy cycles are numbered from 0. If cycle 2^bits − 1 ends with some cells still without a code, those cells receive the code 2^bits − 1 and the conversion ends on that edge.
- R8: `res_sel_i`, sampled with the trigger, sets bits = 7 + `res_sel_i` for codes 0 to 4. Codes 5 to 7 select 11 bits.
- R9: A trigger that arrives while `busy_o` is 1 is ignored: `ramp_ofs_o` keeps its value and the conversion is not restarted.
- R10: The time-over-threshold cell (index 64, top bit of `cmp_hit_i`) is converted and counted for completion like any sample cell.
- R11: `done_o` stays high for exactly one cycle. The codes then hold until the next conversion writes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Channel event, starts a conversion when idle |
| auto_sub_i | input | 1 | 1 = subtract ramp start point from codes |
| res_sel_i | input | 3 | Resolution select (7..11 bits) |
| tbase_i | input | 11 | Shared free-running counter value |
| cmp_hit_i | input | 65 | Per-cell comparator flags, bit 64 = time-over-threshold cell |
| ramp_ofs_o | output | 11 | Counter value captured at ramp start |
| codes_o | output | 715 | Cell codes, 11 bits per cell, cell 0 in the low bits |
| done_o | output | 1 | One-cycle pulse when the conversion ends |
| busy_o | output | 1 | Conversion in progress (ramp on, channel dead) |

## Verification
Each bug in the state shows up at the ports with a known delay. A cell flag stuck set or cleared shows up as a `done_o` pulse one cycle too early or too late against the cycle of the last comparator edge. A wrong busy-cycle count shows up the same way in timeout runs, at each of the five widths. Wrong width or subtraction handling appears in the codes read out in the done cycle; counter runs that cross the wrap point expose a bad modulus. Re-latching after the first hit or a restart by a trigger during busy appears in the same readout, as a changed code or a moved `ramp_ofs_o`.

// File: rtl/rampadc_pkg.sv
package rampadc_pkg;

   typedef enum logic {ST_IDLE, ST_CONV} conv_st_e;

   // resolution code to bit count, saturating at the widest setting
   function automatic int unsigned res_bits(input int unsigned sel,
                                            input int unsigned min_r,
                                            input int unsigned max_r);
      int unsigned b;
      b = min_r + sel;
      if (b > max_r) b = max_r;
      return b;
   endfunction

endpackage

// File: rtl/rampadc_seq.sv
module rampadc_seq
   import rampadc_pkg::*;
#(
   parameter int CNT_W   = 11,
   parameter int RSEL_W  = 3,
   parameter int MIN_RES = 7,
   parameter int MAX_RES = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic              auto_sub_i,
   input  logic [RSEL_W-1:0] res_sel_i,
   input  logic [CNT_W-1:0]  tbase_i,
   input  logic              all_hit_i,
   output logic              start_o,
   output logic              run_o,
   output logic              tmo_o,
   output logic              finish_o,
   output logic [CNT_W-1:0]  mask_o,
   output logic [CNT_W-1:0]  ofs_o,
   output logic              sub_o,
   output logic              done_o
);

   conv_st_e         st_q;
   logic [CNT_W-1:0] elapsed_q;
   logic [CNT_W-1:0] mask_q;
   logic [CNT_W-1:0] ofs_q;
   logic             sub_q;
   logic             done_q;

   function automatic logic [CNT_W-1:0] mask_of(input logic [RSEL_W-1:0] sel);
      logic [CNT_W-1:0] m;
      int unsigned      b;
      b = res_bits(int'(sel), MIN_RES, MAX_RES);
      for (int j = 0; j < CNT_W; j++) m[j] = (j < int'(b));
      return m;
   endfunction

   assign run_o    = (st_q == ST_CONV);
   assign start_o  = trig_i && (st_q == ST_IDLE);
   assign tmo_o    = run_o && (elapsed_q == mask_q);
   assign finish_o = run_o && (all_hit_i || tmo_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         elapsed_q <= '0;
         mask_q    <= '0;
         ofs_q     <= '0;
         sub_q     <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= finish_o;
         if (start_o) begin
            st_q      <= ST_CONV;
            elapsed_q <= '0;
            mask_q    <= mask_of(res_sel_i);
            ofs_q     <= tbase_i;
            sub_q     <= auto_sub_i;
         end else if (finish_o) begin
            st_q <= ST_IDLE;
         end else if (run_o) begin
            elapsed_q <= elapsed_q + 1'b1;
         end
      end
   end

   assign mask_o = mask_q;
   assign ofs_o  = ofs_q;
   assign sub_o  = sub_q;
   assign done_o = done_q;

   // R2: an accepted trigger puts the channel into conversion
   a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> run_o);
   // R9: the ramp start point cannot move during a conversion
   a_r9_ofs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && !finish_o) |=> $stable(ofs_q));
   // R11: done is a single-cycle pulse
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R7: the busy-cycle count never passes full scale
   a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |-> (elapsed_q <= mask_q));

endmodule

// File: rtl/rampadc_code.sv
module rampadc_code #(
   parameter int CNT_W = 11
) (
   input  logic [CNT_W-1:0] tbase_i,
   input  logic [CNT_W-1:0] ofs_i,
   input  logic [CNT_W-1:0] mask_i,
   input  logic             sub_i,
   output logic [CNT_W-1:0] live_o
);

   logic [CNT_W-1:0] diff;

   // modular difference: the mask drops borrows above the chosen width
   assign diff   = tbase_i - ofs_i;
   assign live_o = (sub_i ? diff : tbase_i) & mask_i;

endmodule

// File: rtl/rampadc_cell.sv
module rampadc_cell #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             run_i,
   input  logic             tmo_i,
   input  logic             hit_i,
   input  logic [CNT_W-1:0] live_i,
   input  logic [CNT_W-1:0] full_i,
   output logic [CNT_W-1:0] code_o,
   output logic             got_o
);

   logic [CNT_W-1:0] code_q;
   logic             got_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         got_q  <= 1'b0;
      end else if (start_i) begin
         got_q <= 1'b0;
      end else if (run_i && !got_q) begin
         if (hit_i) begin
            code_q <= live_i;
            got_q  <= 1'b1;
         end else if (tmo_i) begin
            code_q <= full_i;
            got_q  <= 1'b1;
         end
      end
   end

   assign code_o = code_q;
   assign got_o  = got_q;

   // R5: the first hit wins, the code is frozen afterwards
   a_r5_first_hit_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && got_q) |=> $stable(code_q));

endmodule

// File: rtl/rampadc_ctrl.sv
module rampadc_ctrl #(
   parameter int NCELLS   = 64,
   parameter bit TOT_CELL = 1'b1,
   parameter int CNT_W    = 11,
   parameter int RSEL_W   = 3,
   parameter int MIN_RES  = 7,
   parameter int MAX_RES  = 11,
   localparam int NTOT    = NCELLS + (TOT_CELL ? 1 : 0)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  trig_i,
   input  logic                  auto_sub_i,
   input  logic [RSEL_W-1:0]     res_sel_i,
   input  logic [CNT_W-1:0]      tbase_i,
   input  logic [NTOT-1:0]       cmp_hit_i,
   output logic [CNT_W-1:0]      ramp_ofs_o,
   output logic [NTOT*CNT_W-1:0] codes_o,
   output logic                  done_o,
   output logic                  busy_o
);

   generate
      if (CNT_W < MAX_RES) begin : g_bad_cnt
         $error("counter narrower than widest resolution");
      end
      if (MIN_RES < 1 || MIN_RES > MAX_RES) begin : g_bad_res
         $error("resolution range is empty");
      end
      if ((1 << RSEL_W) < (MAX_RES - MIN_RES + 1)) begin : g_bad_sel
         $error("select field cannot reach every resolution");
      end
      if (NCELLS < 1) begin : g_bad_cells
         $error("need at least one sample cell");
      end
   endgenerate

   logic             start, run, tmo, finish, sub;
   logic [CNT_W-1:0] mask, ofs, live;
   logic [NTOT-1:0]  got;
   logic             all_hit;

   assign all_hit = &(got | cmp_hit_i);

   rampadc_seq #(
      .CNT_W(CNT_W), .RSEL_W(RSEL_W), .MIN_RES(MIN_RES), .MAX_RES(MAX_RES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .auto_sub_i(auto_sub_i),
      .res_sel_i(res_sel_i), .tbase_i(tbase_i), .all_hit_i(all_hit),
      .start_o(start), .run_o(run), .tmo_o(tmo), .finish_o(finish),
      .mask_o(mask), .ofs_o(ofs), .sub_o(sub), .done_o(done_o)
   );

   rampadc_code #(.CNT_W(CNT_W)) u_code (
      .tbase_i(tbase_i), .ofs_i(ofs), .mask_i(mask), .sub_i(sub), .live_o(live)
   );

   generate
      for (genvar i = 0; i < NCELLS; i++) begin : g_smp
         rampadc_cell #(.CNT_W(CNT_W)) u_cell (
            .clk(clk), .rst_n(rst_n), .start_i(start), .run_i(run), .tmo_i(tmo),
            .hit_i(cmp_hit_i[i]), .live_i(live), .full_i(mask),
            .code_o(codes_o[i*CNT_W +: CNT_W]), .got_o(got[i])
         );
      end
      if (TOT_CELL) begin : g_tot
         // R10: time-over-threshold cell shares the sample cell datapath
         rampadc_cell #(.CNT_W(CNT_W)) u_cell (
            .clk(clk), .rst_n(rst_n), .start_i(start), .run_i(run), .tmo_i(tmo),
            .hit_i(cmp_hit_i[NTOT-1]), .live_i(live), .full_i(mask),
            .code_o(codes_o[(NTOT-1)*CNT_W +: CNT_W]), .got_o(got[NTOT-1])
         );
      end
   endgenerate

   assign ramp_ofs_o = ofs;
   assign busy_o     = run;

   // R6: a conversion only reports done when every cell holds a code
   a_r6_all_coded: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (&got));
   // R6: done follows the end of a busy period
   a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: tb/tb_rampadc_ctrl.sv
module tb_rampadc_ctrl;

   localparam int NC   = 64;
   localparam int NTOT = NC + 1;
   localparam int CW   = 11;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 trig = 1'b0;
   logic                 auto_sub = 1'b0;
   logic [2:0]           res_sel = '0;
   logic [CW-1:0]        tbase = '0;
   logic [NTOT-1:0]      cmp = '0;
   logic [CW-1:0]        ofs;
   logic [NTOT*CW-1:0]   codes;
   logic                 done, busy;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   int            fire_at [NTOT];
   logic [CW-1:0] hist [0:4095];
   logic [CW-1:0] cur;

   always #4 clk = ~clk;

   rampadc_ctrl dut (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .auto_sub_i(auto_sub),
      .res_sel_i(res_sel), .tbase_i(tbase), .cmp_hit_i(cmp),
      .ramp_ofs_o(ofs), .codes_o(codes), .done_o(done), .busy_o(busy)
   );

   function automatic int bits_of(input int rs);
      return (rs > 4) ? 11 : 7 + rs;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_codes(input string req, input int mask, input bit sub,
                            input logic [CW-1:0] ofs_e);
      int bad = 0;
      for (int i = 0; i < NTOT; i++) begin
         logic [CW-1:0] e, a;
         if (fire_at[i] < 0) e = CW'(mask);
         else if (sub) e = (hist[fire_at[i]] - ofs_e) & CW'(mask);
         else e = hist[fire_at[i]] & CW'(mask);
         a = codes[i*CW +: CW];
         if (a !== e) begin
            bad++;
            $display("FAIL %s cell %0d code: actual=%0h expected=%0h", req, i, a, e);
         end
      end
      checks++;
      if (bad != 0) errors++;
   endtask

   // one conversion: fire_at[] already filled (-1 = never fires)
   task automatic run_conv(input int rs, input bit sub, input logic [CW-1:0] start,
                           input bit poke, input bit scramble, input string req);
      int mask = (1 << bits_of(rs)) - 1;
      int kend = 0;
      bit never = 1'b0;
      logic [CW-1:0] ofs_e;
      logic [NTOT*CW-1:0] snap;
      for (int i = 0; i < NTOT; i++) begin
         if (fire_at[i] < 0 || fire_at[i] > mask) begin
            fire_at[i] = -1;
            never = 1'b1;
         end else if (fire_at[i] > kend) kend = fire_at[i];
      end
      if (never) kend = mask;
      @(negedge clk);
      trig = 1'b1; res_sel = 3'(rs); auto_sub = sub; cmp = '0;
      tbase = start; ofs_e = start; cur = start;
      @(negedge clk);
      trig = 1'b0;
      chk(busy === 1'b1, "R2", "busy after trigger", busy, 1);
      chk(ofs === ofs_e, "R2", "ramp offset", ofs, ofs_e);
      for (int k = 0; k <= kend; k++) begin
         cur = cur + 1'b1;
         tbase = cur;
         hist[k] = cur;
         for (int i = 0; i < NTOT; i++) begin
            if (fire_at[i] >= 0 && k == fire_at[i]) cmp[i] = 1'b1;
            else if (fire_at[i] >= 0 && k > fire_at[i]) cmp[i] = scramble ? 1'($urandom) : 1'b1;
            else cmp[i] = 1'b0;
         end
         trig = poke && (k % 3 == 1);
         @(negedge clk);
         if (k < kend && busy !== 1'b1) begin
            chk(1'b0, req, "busy dropped early", k, kend);
            break;
         end
      end
      trig = 1'b0; cmp = '0;
      chk(done === 1'b1 && busy === 1'b0, req, "done/busy at end", {done, busy}, 2'b10);
      if (poke) chk(ofs === ofs_e, "R9", "offset after ignored triggers", ofs, ofs_e);
      chk_codes(req, mask, sub, ofs_e);
      snap = codes;
      @(negedge clk);
      chk(done === 1'b0, "R11", "done one cycle only", done, 0);
      chk(codes === snap, "R11", "codes hold after done", 0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy === 1'b0 && done === 1'b0, "R1", "flags in reset", {busy, done}, 0);
      chk(ofs === '0 && codes === '0, "R1", "registers in reset", ofs, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3/R6: raw mode, all cells fire early, 11 bits
      for (int i = 0; i < NTOT; i++) fire_at[i] = $urandom_range(0, 30);
      run_conv(4, 1'b0, 11'h100, 1'b0, 1'b0, "R3");
      // R4: subtract mode across counter wrap
      for (int i = 0; i < NTOT; i++) fire_at[i] = $urandom_range(0, 40);
      run_conv(4, 1'b1, 11'h7F0, 1'b0, 1'b0, "R4");
      // R4/R8: subtract at 7 bits, counter wraps
      for (int i = 0; i < NTOT; i++) fire_at[i] = $urandom_range(0, 60);
      run_conv(0, 1'b1, 11'h7E0, 1'b0, 1'b0, "R4");
      // R5: flags bounce after first hit
      for (int i = 0; i < NTOT; i++) fire_at[i] = $urandom_range(0, 25);
      run_conv(2, 1'b0, CW'($urandom), 1'b0, 1'b1, "R5");
      // R9: triggers during busy ignored
      for (int i = 0; i < NTOT; i++) fire_at[i] = $urandom_range(0, 20);
      run_conv(3, 1'b1, CW'($urandom), 1'b1, 1'b0, "R9");
      // R10/R6: time-over-threshold cell is the last to fire
      for (int i = 0; i < NC; i++) fire_at[i] = 2;
      fire_at[NC] = 9;
      run_conv(1, 1'b0, 11'h055, 1'b0, 1'b0, "R10");
      // R6: everything fires in the first busy cycle
      for (int i = 0; i < NTOT; i++) fire_at[i] = 0;
      run_conv(4, 1'b1, 11'h3FF, 1'b0, 1'b0, "R6");
      // R7/R8: timeout at every resolution code
      for (int rs = 0; rs < 8; rs++) begin
         for (int i = 0; i < NTOT; i++) fire_at[i] = ($urandom_range(0, 3) == 0) ? -1 : int'($urandom_range(0, 50));
         fire_at[rs] = -1;
         run_conv(rs, rs[0], CW'($urandom), 1'b0, 1'b1, "R7");
      end
      // R7: last firing exactly in the final busy cycle of 7-bit mode
      for (int i = 0; i < NTOT; i++) fire_at[i] = 5;
      fire_at[17] = 127;
      run_conv(0, 1'b0, 11'h000, 1'b0, 1'b0, "R7");
      // random mix of R3/R4
      for (int n = 0; n < 12; n++) begin
         int rs = $urandom_range(0, 7);
         for (int i = 0; i < NTOT; i++) fire_at[i] = $urandom_range(0, 45);
         run_conv(rs, 1'($urandom), CW'($urandom), 1'($urandom), 1'($urandom), "R8");
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule